// File: doc/BRIEF.md
# Cascadable Magnitude Comparator Chain

This block decides the magnitude relation between two unsigned binary words by passing a verdict through a row of identical 4-bit comparator slices. Each slice looks at its own nibble of both operands. When those nibbles differ, the slice reports its own less-than or greater-than answer. When they match, it hands on whatever verdict arrived from the slice below it. The verdict that leaves the most significant slice is the answer for the whole word.

The number of slices is a parameter, so one design serves 4, 8, 16 or wider operands. The verdict fed into the least significant slice is brought out as three top-level inputs. A stand-alone comparator drives them with the "equal" pattern (equal high, the other two low). A wider comparator built from several of these blocks drives them from the block below. The block has no clock and no storage: the result is a pure function of the inputs.

Top module: `mag_cmp_chain`

## Requirements
- R1: When the operands differ, the result is set by the most significant nibble in which they differ, and the three cascade inputs have no effect, whatever pattern they carry, including patterns with none or several bits high.
- R2: When the operands are equal, the three result outputs copy the three cascade inputs bit for bit, including patterns with none or several bits high.
- R3: With the cascade inputs in the equal pattern (cas_eq_i=1, cas_lt_i=0, cas_gt_i=0), res_lt_o is 1 exactly when operand A is less than operand B as an unsigned number.
- R4: With the cascade inputs in the equal pattern, res_gt_o is 1 exactly when A is greater than B as an unsigned number.
- R5: With the cascade inputs in the equal pattern, res_eq_o is 1 exactly when A equals B.
- R6: With the cascade inputs in the equal pattern, exactly one of the three result outputs is high.
- R7: The operand width is 4 times NSLICES. Two slices give an 8-bit comparator and four slices give a 16-bit comparator, and both follow R1 to R6.
- R8: A difference in a more significant nibble overrides any difference in a less significant nibble. For example, 8-bit A=0x1F against B=0x20 gives less-than.
- R9: Example cases: 8-bit A=0xCB (11001011) against B=0xD4 (11010100) gives less-than, and A=0x0B against B=0x0A (low nibbles 1011 and 1010) gives greater-than.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NSLICES | Operand A, unsigned |
| b_i | input | 4*NSLICES | Operand B, unsigned |
| cas_lt_i | input | 1 | Less-than verdict fed into the least significant slice |
| cas_eq_i | input | 1 | Equal verdict fed into the least significant slice (1 for a stand-alone comparator) |
| cas_gt_i | input | 1 | Greater-than verdict fed into the least significant slice |
| res_lt_o | output | 1 | Final verdict: A less than B |
| res_eq_o | output | 1 | Final verdict: A equal to B |
| res_gt_o | output | 1 | Final verdict: A greater than B |

## Verification
The relational and one-hot assertions assume the cascade inputs carry the legal equal pattern. They are guarded so that they check nothing when those inputs carry anything else. The pass-through assertion needs no such assumption and covers every cascade pattern whenever the operands match. The stimulus holds the equal pattern for the exhaustive 8-bit sweep and for the random 16-bit draws. Only a few directed and random cases drive illegal cascade patterns on purpose, to show they pass through unchanged on equal operands and are ignored otherwise.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    localparam rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

    // Bare relation of two nibbles, with no cascade involvement.
    function automatic rel_t nib_relation(input logic [NIB_W-1:0] x,
                                          input logic [NIB_W-1:0] y);
        rel_t r;
        r.lt = (x < y);
        r.gt = (x > y);
        r.eq = (x == y);
        return r;
    endfunction

endpackage

// File: rtl/mag_nib_cmp.sv
module mag_nib_cmp
    import mag_cmp_pkg::*;
(
    input  logic [NIB_W-1:0] x_i,
    input  logic [NIB_W-1:0] y_i,
    output rel_t             rel_o
);
    always_comb rel_o = nib_relation(x_i, y_i);
endmodule

// File: rtl/mag_slice.sv
module mag_slice
    import mag_cmp_pkg::*;
(
    input  logic [NIB_W-1:0] x_i,
    input  logic [NIB_W-1:0] y_i,
    input  rel_t             below_i,
    output rel_t             above_o
);
    rel_t local_rel;

    mag_nib_cmp u_nib (
        .x_i   (x_i),
        .y_i   (y_i),
        .rel_o (local_rel)
    );

    // Local difference wins; a tie defers to the less significant verdict.
    always_comb begin
        if (local_rel.eq) above_o = below_i;
        else              above_o = local_rel;
    end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import mag_cmp_pkg::*;
#(
    parameter int unsigned NSLICES = 2
) (
    input  logic [NIB_W*NSLICES-1:0] a_i,
    input  logic [NIB_W*NSLICES-1:0] b_i,
    input  logic                     cas_lt_i,
    input  logic                     cas_eq_i,
    input  logic                     cas_gt_i,
    output logic                     res_lt_o,
    output logic                     res_eq_o,
    output logic                     res_gt_o
);
    localparam int unsigned OP_W = NIB_W * NSLICES;

    rel_t link [0:NSLICES];

    always_comb begin
        link[0].lt = cas_lt_i;
        link[0].eq = cas_eq_i;
        link[0].gt = cas_gt_i;
    end

    for (genvar s = 0; s < NSLICES; s++) begin : g_slice
        mag_slice u_slice (
            .x_i     (a_i[s*NIB_W +: NIB_W]),
            .y_i     (b_i[s*NIB_W +: NIB_W]),
            .below_i (link[s]),
            .above_o (link[s+1])
        );
    end

    always_comb begin
        res_lt_o = link[NSLICES].lt;
        res_eq_o = link[NSLICES].eq;
        res_gt_o = link[NSLICES].gt;
    end

    if (OP_W < NIB_W) begin : g_bad_param
        initial $error("NSLICES must be at least 1");
    end
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk
    import mag_cmp_pkg::*;
#(
    parameter int unsigned NSLICES = 2
) (
    input logic [NIB_W*NSLICES-1:0] a_i,
    input logic [NIB_W*NSLICES-1:0] b_i,
    input logic                     cas_lt_i,
    input logic                     cas_eq_i,
    input logic                     cas_gt_i,
    input logic                     res_lt_o,
    input logic                     res_eq_o,
    input logic                     res_gt_o
);
    logic legal_in;
    always_comb legal_in = cas_eq_i && !cas_lt_i && !cas_gt_i;

    always_comb begin
        if (legal_in) begin
            a_r6_one_hot: assert ($countones({res_lt_o, res_eq_o, res_gt_o}) == 1)
                else $error("R6: result not one-hot");
            a_r3_lt_matches: assert (res_lt_o == (a_i < b_i))
                else $error("R3: lt mismatch");
            a_r4_gt_matches: assert (res_gt_o == (a_i > b_i))
                else $error("R4: gt mismatch");
        end
        if (a_i == b_i) begin
            a_r2_passthrough: assert ({res_lt_o, res_eq_o, res_gt_o} ==
                                      {cas_lt_i, cas_eq_i, cas_gt_i})
                else $error("R2: cascade not copied");
        end else begin
            a_r1_cascade_ignored: assert (!res_eq_o && (res_lt_o != res_gt_o))
                else $error("R1: differing operands gave no strict verdict");
        end
    end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.NSLICES(NSLICES)) chk_i (
    .a_i      (a_i),
    .b_i      (b_i),
    .cas_lt_i (cas_lt_i),
    .cas_eq_i (cas_eq_i),
    .cas_gt_i (cas_gt_i),
    .res_lt_o (res_lt_o),
    .res_eq_o (res_eq_o),
    .res_gt_o (res_gt_o)
);

// File: tb/mag_cmp_chain_tb.sv
module mag_cmp_chain_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic done = 1'b0;

    // 8-bit instance
    logic [7:0]  a8, b8;
    logic [2:0]  cin8;      // {lt, eq, gt}
    logic        lt8, eq8, gt8;

    mag_cmp_chain #(.NSLICES(2)) dut_i (
        .a_i (a8), .b_i (b8),
        .cas_lt_i (cin8[2]), .cas_eq_i (cin8[1]), .cas_gt_i (cin8[0]),
        .res_lt_o (lt8), .res_eq_o (eq8), .res_gt_o (gt8)
    );

    // 16-bit instance
    logic [15:0] a16, b16;
    logic [2:0]  cin16;
    logic        lt16, eq16, gt16;

    mag_cmp_chain #(.NSLICES(4)) dut16_i (
        .a_i (a16), .b_i (b16),
        .cas_lt_i (cin16[2]), .cas_eq_i (cin16[1]), .cas_gt_i (cin16[0]),
        .res_lt_o (lt16), .res_eq_o (eq16), .res_gt_o (gt16)
    );

    // Expected {lt,eq,gt} from the requirements.
    function automatic logic [2:0] expect_rel(input logic [15:0] a,
                                              input logic [15:0] b,
                                              input logic [2:0]  cin);
        if (a < b)      return 3'b100;
        else if (a > b) return 3'b001;
        else            return cin;
    endfunction

    task automatic check(input string tag, input logic [2:0] got,
                         input logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got lt/eq/gt=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic run8(input string tag, input logic [7:0] a,
                        input logic [7:0] b, input logic [2:0] cin);
        a8 = a; b8 = b; cin8 = cin;
        #1;
        check(tag, {lt8, eq8, gt8}, expect_rel({8'h0, a}, {8'h0, b}, cin));
    endtask

    task automatic run16(input string tag, input logic [15:0] a,
                         input logic [15:0] b, input logic [2:0] cin);
        a16 = a; b16 = b; cin16 = cin;
        #1;
        check(tag, {lt16, eq16, gt16}, expect_rel(a, b, cin));
    endtask

    initial begin
        int unsigned seed_dummy;
        a8 = '0; b8 = '0; cin8 = 3'b010;
        a16 = '0; b16 = '0; cin16 = 3'b010;
        seed_dummy = $urandom(32'd5150);
        #5;
        check("R5 initial equal zero", {lt8, eq8, gt8}, 3'b010);

        // R9 directed examples
        run8("R9 0xCB vs 0xD4 less", 8'hCB, 8'hD4, 3'b010);
        check("R9 literal lt", {lt8, eq8, gt8}, 3'b100);
        run8("R9 0x0B vs 0x0A greater", 8'h0B, 8'h0A, 3'b010);
        check("R9 literal gt", {lt8, eq8, gt8}, 3'b001);

        // R8 upper nibble overrides lower nibble
        run8("R8 0x1F vs 0x20", 8'h1F, 8'h20, 3'b010);
        run8("R8 0xF0 vs 0x0F", 8'hF0, 8'h0F, 3'b010);

        // R1 cascade inputs ignored when operands differ
        run8("R1 differ cin=111", 8'h35, 8'h36, 3'b111);
        run8("R1 differ cin=000", 8'h80, 8'h7F, 3'b000);
        run8("R1 differ cin=100", 8'h44, 8'h43, 3'b100);
        run16("R1 16b differ cin=101", 16'h1234, 16'h1235, 3'b101);

        // R2 pass-through on equal operands, all eight patterns
        for (int p = 0; p < 8; p++) begin
            run8("R2 equal passthrough", 8'hA5, 8'hA5, p[2:0]);
            run16("R2 16b equal passthrough", 16'hBEEF, 16'hBEEF, p[2:0]);
        end

        // R3 R4 R5 R6: exhaustive 8-bit sweep with legal cascade
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                run8("R3 R4 R5 R6 exhaustive 8b", i[7:0], j[7:0], 3'b010);
            end
        end

        // R7 16-bit random and boundary cases
        run16("R7 16b max vs max-1", 16'hFFFF, 16'hFFFE, 3'b010);
        run16("R7 16b top nibble", 16'h8000, 16'h7FFF, 3'b010);
        run16("R7 16b zero vs one", 16'h0000, 16'h0001, 3'b010);
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = (k % 4 == 0) ? (ra ^ (16'h1 << (k % 16))) : 16'($urandom);
            run16("R7 16b random", ra, rb, 3'b010);
        end
        // a few random operands with random cascade patterns (R1/R2)
        for (int k = 0; k < 200; k++) begin
            logic [7:0] ra;
            ra = 8'($urandom);
            run8("R1 R2 random cin", ra, (k % 2 == 0) ? ra : 8'($urandom),
                 3'($urandom));
        end

        done = 1'b1;
    end

    // Watchdog
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule